// File: doc/BRIEF.md
# Timer with Compare and Capture Channels

This block is a 16-bit timer/counter with a clock prescaler, a reload register and four compare/capture channels. It can count in three ways. As a timer it counts prescaled clock cycles. As an event counter it counts falling edges of an external input, sampled once per machine cycle. As a gated timer it counts prescaled cycles only while that input is high. On overflow the count either loads the reload register or wraps to zero. A falling edge on a separate trigger input can also load the reload register.

Each channel is set to one of four modes:
- **Off:** the channel does nothing.
- **Compare:** the channel drives one bit of a PWM-style output bus. The bit is set when the timer equals the channel register and cleared when the timer reloads.
- **Edge capture:** the channel latches the timer value on a rising edge of its capture input.
- **Software capture:** the channel latches the timer value when software writes the channel register.

Software reaches every register through a simple write port and a read port. All external inputs pass through two-stage synchronizers before any edge detection. The overflow flag and the per-channel flags are sticky, and they double as interrupt request outputs.

Top module: `cc_timer`

## Requirements
- R1: After reset the control word, timer, reload register, all channel registers, all flags and `cmp_out` read as zero. Register addresses are: 0 control, 1 timer, 2 reload, 3 flags, 4+i channel i. `rd_data` shows the register selected by `rd_addr` one clock later.
- R2: The control word holds the run mode in bits [1:0] (0 stop, 1 timer, 2 event, 3 gated). In timer mode the count rises once every PRE_BASE clocks, or every 2*PRE_BASE clocks when control bit 2 is set. Any control write restarts the prescaler, so the first increment lands PRE_BASE (or 2*PRE_BASE) clocks after the write.
- R3: In event mode each falling edge of `cnt_in` adds exactly one to the count. The input is sampled only on clocks where `cyc_en` is high, so a pulse that starts and ends while `cyc_en` is low is not counted.
- R4: In event mode, with `cyc_en` held high, a fall of `cnt_in` changes the timer on the third clock edge after the first edge that samples the low level. The steps are two synchronizer stages, then detection, then the increment in the following cycle.
- R5: In gated mode the count advances at the prescaled rate while `cnt_in` is high and holds while it is low.
- R6: When the count increments past 0xFFFF, the overflow flag (flags bit 0) is set. The timer then loads the reload register if control bit 3 is 0, and wraps to 0 if it is 1.
- R7: When control bit 3 is 1, a falling edge of `trig_in` loads the reload register into the timer in any run mode. When bit 3 is 0, `trig_in` has no effect on the timer.
- R8: Control bits [9+2i:8+2i] select the mode of channel i: 0 off, 1 compare, 2 edge capture, 3 software capture. In compare mode, `cmp_out[i]` rises one clock after the timer equals channel register i, and flags bit 1+i is set. `cmp_out[i]` is cleared when the timer overflows or is trigger-reloaded. It is 0 in every other mode.
- R9: In edge-capture mode a rising edge of `cap_in[i]` copies the timer into channel register i and sets flags bit 1+i. In any other mode `cap_in[i]` leaves the register unchanged.
- R10: In software-capture mode a write to channel register i stores the timer value, not the written data, and sets flags bit 1+i. In the other modes the written data is stored.
- R11: Flags stay set until a write to the flags address with a 1 in that bit position. A new event in the same cycle keeps the flag set.
- R12: In stop mode, with no timer write and no trigger reload, the timer holds its value. A write to the timer address loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Machine-cycle enable for event sampling |
| cnt_in | input | 1 | Event count input / gate input |
| trig_in | input | 1 | Reload trigger input (falling edge) |
| cap_in | input | NCH | Per-channel capture inputs (rising edge) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | W | Registered read data |
| cmp_out | output | NCH | Compare outputs |
| irq_ovf | output | 1 | Overflow flag / interrupt request |
| irq_cc | output | NCH | Channel match/capture flags / interrupt requests |

## Verification
The bench builds the block with PRE_BASE=3, W=16 and NCH=4. The short prescale makes it affordable to sweep every stop window from 1 to 30 clocks at both divide settings and compare the count against floor(window/period). Presetting the 16-bit timer just below 0xFFFF reaches overflow within a few ticks, so both reload choices can be tested. Timer values are stepped past four different compare values at once, so the expected output mask and flag mask follow from simple comparisons.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    RUN_STOP  = 2'd0,
    RUN_TIMER = 2'd1,
    RUN_EVENT = 2'd2,
    RUN_GATED = 2'd3
  } run_mode_t;

  typedef enum logic [1:0] {
    CH_OFF      = 2'd0,
    CH_COMPARE  = 2'd1,
    CH_CAP_EDGE = 2'd2,
    CH_CAP_SW   = 2'd3
  } ch_mode_t;

  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_TIMER   = 1;
  localparam int unsigned A_RELOAD  = 2;
  localparam int unsigned A_FLAGS   = 3;
  localparam int unsigned A_CC_BASE = 4;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/cct_prescale.sv
module cct_prescale #(
  parameter int BASE = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic div2,
  output logic tick
);
  localparam int CW = $clog2(2 * BASE);

  logic [CW-1:0] pre;
  logic [CW-1:0] lim;

  assign lim  = div2 ? CW'(2 * BASE - 1) : CW'(BASE - 1);
  assign tick = (pre == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) pre <= '0;
    else if (tick)  pre <= '0;
    else            pre <= pre + CW'(1);
  end

  // R2: the divider never runs past the selected period
  a_r2_pre_range: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (pre <= lim));
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  run_mode_t mode,
  input  logic      trig_sel,
  input  logic      tick,
  input  logic      cyc_en,
  input  logic      ev_in,
  input  logic      trig_in,
  input  logic      tmr_we,
  input  logic      rld_we,
  input  logic [W-1:0] wdata,
  input  logic      ovf_clr,
  output logic [W-1:0] tmr,
  output logic [W-1:0] rld,
  output logic      ovf_flag,
  output logic      wrap_evt
);
  logic ev_prev, ev_det, trig_prev;
  logic inc, ovf, trig_ld, ovf_hit;

  always_comb begin
    unique case (mode)
      RUN_TIMER: inc = tick;
      RUN_EVENT: inc = ev_det;
      RUN_GATED: inc = tick & ev_in;
      default:   inc = 1'b0;
    endcase
  end

  assign trig_ld  = trig_sel & trig_prev & ~trig_in;
  assign ovf      = inc & (tmr == '1);
  assign ovf_hit  = ovf & ~tmr_we & ~trig_ld;
  assign wrap_evt = ~tmr_we & (trig_ld | ovf);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_prev   <= 1'b0;
      ev_det    <= 1'b0;
      trig_prev <= 1'b0;
      tmr       <= '0;
      rld       <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      if (cyc_en) ev_prev <= ev_in;
      ev_det    <= cyc_en & ev_prev & ~ev_in;
      trig_prev <= trig_in;
      if (rld_we) rld <= wdata;
      if (tmr_we)       tmr <= wdata;
      else if (trig_ld) tmr <= rld;
      else if (ovf)     tmr <= trig_sel ? '0 : rld;
      else if (inc)     tmr <= tmr + W'(1);
      if (ovf_hit)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  // R12: a stopped timer holds unless written or trigger-reloaded
  a_r12_stop_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_STOP && !tmr_we && !trig_ld) |=> $stable(tmr));
  // R4: in event mode the count only moves one cycle after a detection
  a_r4_event_lag: assert property (@(posedge clk) disable iff (rst)
    (mode == RUN_EVENT && !ev_det && !tmr_we && !trig_ld) |=> $stable(tmr));
  // R11: overflow flag is sticky
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  ch_mode_t     mode,
  input  logic [W-1:0] tmr,
  input  logic         wrap_evt,
  input  logic         cap_s,
  input  logic         bus_we,
  input  logic [W-1:0] wdata,
  input  logic         flag_clr,
  output logic [W-1:0] cc,
  output logic         cmp_out,
  output logic         flag
);
  logic cap_prev, cap_hit, match;

  assign cap_hit = ((mode == CH_CAP_EDGE) & cap_s & ~cap_prev)
                 | ((mode == CH_CAP_SW) & bus_we);
  assign match   = (mode == CH_COMPARE) & (tmr == cc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_prev <= 1'b0;
      cc       <= '0;
      cmp_out  <= 1'b0;
      flag     <= 1'b0;
    end else begin
      cap_prev <= cap_s;
      if (cap_hit)     cc <= tmr;
      else if (bus_we) cc <= wdata;
      if (mode != CH_COMPARE || wrap_evt) cmp_out <= 1'b0;
      else if (match)                     cmp_out <= 1'b1;
      if (cap_hit || match) flag <= 1'b1;
      else if (flag_clr)    flag <= 1'b0;
    end
  end

  // R8: a reload always leaves the compare output low
  a_r8_cmp_clear: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> !cmp_out);
  // R9: a capture stores the timer value seen at the capture edge
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> (cc == $past(tmr)));
  // R11: channel flag is sticky
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int W        = 16,
  parameter int NCH      = 4,
  parameter int PRE_BASE = 12,
  localparam int AW      = $clog2(A_CC_BASE + NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cyc_en,
  input  logic           cnt_in,
  input  logic           trig_in,
  input  logic [NCH-1:0] cap_in,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data,
  output logic [NCH-1:0] cmp_out,
  output logic           irq_ovf,
  output logic [NCH-1:0] irq_cc
);
  localparam int CHB = 8;

  logic [1:0]       mode_q;
  logic             div2_q, tsel_q;
  logic [2*NCH-1:0] chm_q;
  logic             we_ctrl, we_tmr, we_rld, we_flags;
  logic             tick, wrap_evt;
  logic [W-1:0]     tmr, rld;
  logic [NCH+1:0]   syn;
  logic [W-1:0]     cc_v [NCH];
  logic [W-1:0]     rd_nx;

  assign we_ctrl  = wr_en && (wr_addr == AW'(A_CTRL));
  assign we_tmr   = wr_en && (wr_addr == AW'(A_TIMER));
  assign we_rld   = wr_en && (wr_addr == AW'(A_RELOAD));
  assign we_flags = wr_en && (wr_addr == AW'(A_FLAGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      div2_q <= 1'b0;
      tsel_q <= 1'b0;
      chm_q  <= '0;
    end else if (we_ctrl) begin
      mode_q <= wr_data[1:0];
      div2_q <= wr_data[2];
      tsel_q <= wr_data[3];
      chm_q  <= wr_data[CHB +: 2*NCH];
    end
  end

  cct_sync #(.W(NCH + 2)) u_sync (
    .clk(clk), .rst(rst), .d({cap_in, trig_in, cnt_in}), .q(syn));

  cct_prescale #(.BASE(PRE_BASE)) u_pre (
    .clk(clk), .rst(rst), .clr(we_ctrl), .div2(div2_q), .tick(tick));

  cct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .mode(run_mode_t'(mode_q)), .trig_sel(tsel_q),
    .tick(tick), .cyc_en(cyc_en), .ev_in(syn[0]), .trig_in(syn[1]),
    .tmr_we(we_tmr), .rld_we(we_rld), .wdata(wr_data),
    .ovf_clr(we_flags & wr_data[0]), .tmr(tmr), .rld(rld),
    .ovf_flag(irq_ovf), .wrap_evt(wrap_evt));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cct_channel #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .mode(ch_mode_t'(chm_q[2*i +: 2])), .tmr(tmr),
      .wrap_evt(wrap_evt), .cap_s(syn[2+i]),
      .bus_we(wr_en && (wr_addr == AW'(A_CC_BASE + i))), .wdata(wr_data),
      .flag_clr(we_flags & wr_data[1+i]), .cc(cc_v[i]),
      .cmp_out(cmp_out[i]), .flag(irq_cc[i]));
  end

  always_comb begin
    rd_nx = '0;
    if (rd_addr == AW'(A_CTRL)) begin
      rd_nx[3:0]             = {tsel_q, div2_q, mode_q};
      rd_nx[CHB +: 2*NCH]    = chm_q;
    end
    if (rd_addr == AW'(A_TIMER))  rd_nx = tmr;
    if (rd_addr == AW'(A_RELOAD)) rd_nx = rld;
    if (rd_addr == AW'(A_FLAGS))  rd_nx[NCH:0] = {irq_cc, irq_ovf};
    for (int i = 0; i < NCH; i++)
      if (rd_addr == AW'(A_CC_BASE + i)) rd_nx = cc_v[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nx;
  end
endmodule

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  localparam int W = 16, NCH = 4, PB = 3;
  localparam int AW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc_en, cnt_in = 1'b1, trig_in = 1'b1;
  logic [NCH-1:0] cap_in = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic [NCH-1:0] cmp_out, irq_cc;
  logic irq_ovf;
  int checks = 0, fails = 0, cyc_mode = 0, ph = 0;
  bit done = 1'b0;
  logic [W-1:0] v;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ph <= (ph == 2) ? 0 : ph + 1;
    cyc_en <= (cyc_mode == 0) ? 1'b1 : (cyc_mode == 1) ? 1'b0 : (ph == 0);
  end

  cc_timer #(.W(W), .NCH(NCH), .PRE_BASE(PB)) u_cc_timer (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .cnt_in(cnt_in), .trig_in(trig_in),
    .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_out(cmp_out),
    .irq_ovf(irq_ovf), .irq_cc(irq_cc));

  function automatic logic [15:0] cw(input logic [1:0] m, input logic d,
                                     input logic t, input logic [7:0] ch);
    return {ch, 4'b0000, t, d, m};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [W-1:0] e);
    logic [W-1:0] t;
    rd(a, t);
    chk(tag, t, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) rdchk("R1 reset register", a, 16'h0);
    chk("R1 reset cmp_out", cmp_out, 4'h0);

    // R2 timer mode prescale sweep
    for (int d = 0; d < 2; d++)
      for (int k = 1; k <= 30; k++) begin
        wr(1, 16'h0);
        wr(0, cw(2'd1, d[0], 1'b0, 8'h00));
        idle(k - 1);
        wr(0, cw(2'd0, d[0], 1'b0, 8'h00));
        rdchk("R2 prescaled count", 1, 16'(k / (d == 1 ? 2 * PB : PB)));
      end

    // R4 event latency
    wr(1, 16'h0);
    wr(0, cw(2'd2, 1'b0, 1'b0, 8'h00));
    rd(1, v);
    cnt_in = 1'b0;
    idle(4);
    chk("R4 no change before third edge", rd_data, 16'h0);
    idle(1);
    chk("R4 change on third edge", rd_data, 16'h1);
    cnt_in = 1'b1;
    idle(3);
    // R3 event counting with varied pulse widths
    for (int n = 1; n <= 6; n++) begin
      cnt_in = 1'b0; idle(n + 1);
      cnt_in = 1'b1; idle(n + 2);
    end
    idle(4);
    rdchk("R3 falling edges counted", 1, 16'd7);
    // R3 pulse hidden while cyc_en low
    cyc_mode = 1; idle(2);
    cnt_in = 1'b0; idle(5);
    cnt_in = 1'b1; idle(5);
    cyc_mode = 0; idle(5);
    rdchk("R3 pulse during cyc_en low ignored", 1, 16'd7);
    // R3 one machine cycle every three clocks
    cyc_mode = 2;
    for (int n = 0; n < 4; n++) begin
      cnt_in = 1'b0; idle(7);
      cnt_in = 1'b1; idle(7);
    end
    idle(6);
    cyc_mode = 0;
    rdchk("R3 sparse machine cycles", 1, 16'd11);

    // R5 gated mode
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'h00));
    cnt_in = 1'b0; idle(4);
    wr(1, 16'h0);
    wr(0, cw(2'd3, 1'b0, 1'b0, 8'h00));
    idle(23);
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'h00));
    rdchk("R5 gate low holds", 1, 16'h0);
    cnt_in = 1'b1; idle(4);
    wr(0, cw(2'd3, 1'b0, 1'b0, 8'h00));
    idle(23);
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'h00));
    rdchk("R5 gate high counts", 1, 16'd8);

    // R6 overflow with reload register
    wr(2, 16'hFFF0);
    wr(1, 16'hFFFD);
    wr(0, cw(2'd1, 1'b0, 1'b0, 8'h00));
    idle(11);
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'h00));
    rdchk("R6 reload on overflow", 1, 16'hFFF1);
    rdchk("R6 overflow flag", 3, 16'h0001);
    chk("R6 irq_ovf", irq_ovf, 1'b1);
    idle(10);
    rdchk("R11 flag stays set", 3, 16'h0001);
    wr(3, 16'h0001);
    rdchk("R11 flag cleared", 3, 16'h0000);
    // R6 wrap to zero
    wr(1, 16'hFFFE);
    wr(0, cw(2'd1, 1'b0, 1'b1, 8'h00));
    idle(8);
    wr(0, cw(2'd0, 1'b0, 1'b1, 8'h00));
    rdchk("R6 wrap to zero", 1, 16'h0001);
    rdchk("R6 overflow flag on wrap", 3, 16'h0001);
    wr(3, 16'h0001);

    // R7 trigger reload
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'h00));
    wr(1, 16'h1234);
    wr(2, 16'hABCD);
    trig_in = 1'b0; idle(4); trig_in = 1'b1; idle(4);
    rdchk("R7 trigger ignored when disabled", 1, 16'h1234);
    idle(20);
    rdchk("R12 stop holds", 1, 16'h1234);
    wr(0, cw(2'd0, 1'b0, 1'b1, 8'h00));
    trig_in = 1'b0; idle(4); trig_in = 1'b1; idle(4);
    rdchk("R7 trigger reload", 1, 16'hABCD);

    // R8 compare sweep over four channels
    for (int i = 0; i < 4; i++) wr(4 + i, 16'(2 * i + 1));
    wr(0, cw(2'd0, 1'b0, 1'b1, 8'b01010101));
    for (int t = 0; t <= 8; t++) begin
      logic [3:0] m;
      wr(1, 16'(t));
      idle(2);
      for (int i = 0; i < 4; i++) m[i] = (t >= 2 * i + 1);
      chk("R8 compare mask", cmp_out, m);
      rdchk("R8 compare flags", 3, {11'b0, m, 1'b0});
    end
    trig_in = 1'b0; idle(4); trig_in = 1'b1; idle(4);
    chk("R8 cleared by trigger reload", cmp_out, 4'h0);
    rdchk("R11 channel flags sticky", 3, 16'h001E);
    wr(3, 16'h001F);
    rdchk("R11 channel flags cleared", 3, 16'h0000);
    // R8 compare then clear on overflow
    wr(4, 16'hFFFE);
    wr(2, 16'h0000);
    wr(1, 16'hFFFC);
    wr(0, cw(2'd1, 1'b0, 1'b0, 8'b00000001));
    idle(8);
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'b00000001));
    chk("R8 set after match", cmp_out, 4'h1);
    wr(0, cw(2'd1, 1'b0, 1'b0, 8'b00000001));
    idle(2);
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'b00000001));
    chk("R8 cleared by overflow", cmp_out, 4'h0);
    rdchk("R6 overflow after pwm period", 1, 16'h0000);
    wr(3, 16'h001F);

    // R9 edge capture on ch2, ch3 in compare ignores its input
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'b01100000));
    wr(1, 16'h0777);
    cap_in = 4'b1100; idle(5); cap_in = 4'b0000; idle(3);
    rdchk("R9 edge capture value", 6, 16'h0777);
    rdchk("R9 compare channel ignores capture input", 7, 16'h0007);
    rdchk("R9 capture flag", 3, 16'h0008);
    wr(1, 16'h0888);
    cap_in = 4'b0100; idle(5); cap_in = 4'b0000; idle(3);
    rdchk("R9 second capture", 6, 16'h0888);

    // R10 software capture on ch1
    wr(3, 16'h001F);
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'b00001100));
    wr(1, 16'h4321);
    wr(5, 16'hFFFF);
    rdchk("R10 software capture value", 5, 16'h4321);
    rdchk("R10 software capture flag", 3, 16'h0004);
    wr(0, cw(2'd0, 1'b0, 1'b0, 8'b00000100));
    wr(5, 16'h00AA);
    rdchk("R10 plain write in compare mode", 5, 16'h00AA);
    rdchk("R1 control readback", 0, cw(2'd0, 1'b0, 1'b0, 8'b00000100));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule